// File: doc/BRIEF.md
# Parallel 32-Point Inverse Transform with Odd-Channel Sign Fix

This block takes one complete set of 32 complex bins from a uniform filter bank each clock cycle and returns the 32 time-domain channel samples. The inverse transform is built from a forward radix-2 decimation-in-time network. The imaginary part of every input is negated on entry and the imaginary part of every result is negated on exit. Each of the five butterfly ranks halves its results, so the overall gain is 1/32 and no rank can overflow. A pipeline register follows every rank. A new input set may arrive on every cycle, and every accepted set produces exactly one output set.

The filter bank decimates by half the channel count, so every other channel carries a rotation of pi per output sample. The last step corrects this by negating both components of every odd-numbered channel, and it saturates, so the most negative value becomes the most positive one. Even-numbered channels leave unchanged. Input bins are wired into the network in bit-reversed order internally, so both the input ports and the output ports are indexed in natural order.

Top module: `chan_ifft32`

## Requirements
- R1: For every even channel n, the output is (1/32)·sum over k of X[k]·exp(+j·2·pi·k·n/32), within 4 LSB on both I and Q. Bin k sits in bits [16k+15:16k] of the input buses, channel n in bits [16n+15:16n] of the output buses, and values are two's complement.
- R2: For every odd channel n, the output is the negative of the R1 value, within 4 LSB.
- R3: out_valid rises exactly 5 clock cycles after an accepted in_valid. Back-to-back input sets each give their own output set, in order, with no gaps added. out_valid is low 5 cycles after a cycle with in_valid low.
- R4: While rst_n is low, and until the first accepted input has passed through, out_valid is low.
- R5: An input set that is all zero gives an output set that is exactly zero on every channel.
- R6: The odd-channel sign fix saturates: an odd channel never shows -32768 on I, and an even channel never shows -32768 on Q. An even channel passes -32768 on I without change.
- R7: When every bin holds the same real value (full-scale 23000), channel 0 gives that value and all other channels stay near zero, with no wraparound inside the network.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| in_valid | input | 1 | Marks the current input set as valid |
| in_re | input | 512 | Real parts of bins 0..31, 16 bits each |
| in_im | input | 512 | Imaginary parts of bins 0..31, 16 bits each |
| out_valid | output | 1 | Marks the current output set as valid |
| out_re | output | 512 | I components of channels 0..31, 16 bits each |
| out_im | output | 512 | Q components of channels 0..31, 16 bits each |

## Verification
The properties assume that each input bin has a complex magnitude of at most 32768. Under that limit, halving at every rank keeps each intermediate value inside 16 bits, and saturation can only shave off twiddle rounding. They also assume that in_valid is driven to a known level on every cycle once reset is released. The stimulus keeps to this envelope. Random bins use components in ±16000, structured patterns stay at or below 23000 per component, and the single extreme pattern puts -32768 in the real parts with zero imaginary parts. in_valid is held low whenever the bench is not presenting a set.

// File: rtl/chan_ifft32.sv
module chan_ifft32 #(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [32*DW-1:0]  in_re,
  input  logic [32*DW-1:0]  in_im,
  output logic              out_valid,
  output logic [32*DW-1:0]  out_re,
  output logic [32*DW-1:0]  out_im
);
  localparam int NP  = 32;
  localparam int NS  = 5;
  localparam int TF  = 14;
  localparam int CW  = 16;
  localparam int PW  = DW + CW + 1;
  localparam int TWW = PW - TF;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  function automatic int bitrev(input int v);
    int r;
    r = 0;
    for (int i = 0; i < NS; i++) if (((v >> i) & 1) == 1) r = r | (1 << (NS - 1 - i));
    return r;
  endfunction

  function automatic int qcos(input int m);
    case (m)
      0: return 16384;
      1: return 16069;
      2: return 15137;
      3: return 13623;
      4: return 11585;
      5: return 9102;
      6: return 6270;
      7: return 3196;
      default: return 0;
    endcase
  endfunction

  function automatic int tw_cos(input int k);
    return (k <= 8) ? qcos(k) : -qcos(16 - k);
  endfunction

  function automatic int tw_sin(input int k);
    return (k <= 8) ? qcos(8 - k) : qcos(k - 8);
  endfunction

  function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
    return (v == MINV) ? MAXV : -v;
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [TWW-1:0] v);
    if (v > TWW'(MAXV)) return MAXV;
    else if (v < TWW'(MINV)) return MINV;
    else return v[DW-1:0];
  endfunction

  logic signed [DW-1:0] a_re [NP];
  logic signed [DW-1:0] a_im [NP];
  logic signed [DW-1:0] n_re [NS][NP];
  logic signed [DW-1:0] n_im [NS][NP];
  logic signed [DW-1:0] p_re [NS][NP];
  logic signed [DW-1:0] p_im [NS][NP];
  logic [NS-1:0]        vpipe;

  for (genvar k = 0; k < NP; k++) begin : g_in
    localparam int R = bitrev(k);
    assign a_re[R] = in_re[k*DW +: DW];
    assign a_im[R] = neg_sat(in_im[k*DW +: DW]);
  end

  for (genvar s = 0; s < NS; s++) begin : g_stage
    for (genvar b = 0; b < NP/2; b++) begin : g_bfly
      localparam int H = 1 << s;
      localparam int I = ((b >> s) << (s + 1)) | (b & (H - 1));
      localparam int J = I + H;
      localparam int K = (b & (H - 1)) << (NS - 1 - s);
      localparam logic signed [CW-1:0] WC = CW'(tw_cos(K));
      localparam logic signed [CW-1:0] WS = CW'(tw_sin(K));

      logic signed [DW-1:0]  ar, ai, br, bi;
      logic signed [PW-1:0]  mr, mi;
      logic signed [TWW-1:0] tr, ti, sr, si, dr, di;

      if (s == 0) begin : g_src0
        assign ar = a_re[I];
        assign ai = a_im[I];
        assign br = a_re[J];
        assign bi = a_im[J];
      end else begin : g_srcn
        assign ar = p_re[s-1][I];
        assign ai = p_im[s-1][I];
        assign br = p_re[s-1][J];
        assign bi = p_im[s-1][J];
      end

      assign mr = PW'(br) * PW'(WC) + PW'(bi) * PW'(WS);
      assign mi = PW'(bi) * PW'(WC) - PW'(br) * PW'(WS);
      assign tr = TWW'(mr >>> TF);
      assign ti = TWW'(mi >>> TF);
      assign sr = TWW'(ar) + tr;
      assign si = TWW'(ai) + ti;
      assign dr = TWW'(ar) - tr;
      assign di = TWW'(ai) - ti;

      assign n_re[s][I] = clip(sr >>> 1);
      assign n_im[s][I] = clip(si >>> 1);
      assign n_re[s][J] = clip(dr >>> 1);
      assign n_im[s][J] = clip(di >>> 1);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < NP; i++) begin
        p_re[s][i] <= n_re[s][i];
        p_im[s][i] <= n_im[s][i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[NS-2:0], in_valid};
  end

  assign out_valid = vpipe[NS-1];

  for (genvar n = 0; n < NP; n++) begin : g_out
    if (n % 2 == 1) begin : g_odd
      assign out_re[n*DW +: DW] = neg_sat(p_re[NS-1][n]);
      assign out_im[n*DW +: DW] = p_im[NS-1][n];
    end else begin : g_even
      assign out_re[n*DW +: DW] = p_re[NS-1][n];
      assign out_im[n*DW +: DW] = neg_sat(p_im[NS-1][n]);
    end
  end
endmodule

module chan_ifft32_chk #(
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [32*DW-1:0] in_re,
  input logic [32*DW-1:0] in_im,
  input logic             out_valid,
  input logic [32*DW-1:0] out_re,
  input logic [32*DW-1:0] out_im
);
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  p_valid_after_five_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##5 out_valid);

  p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##5 !out_valid);

  p_reset_quiet_r4: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  p_zero_in_zero_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_re == '0 && in_im == '0) |-> ##5 (out_re == '0 && out_im == '0));

  for (genvar n = 0; n < 32; n++) begin : g_sat
    if (n % 2 == 1) begin : g_odd
      p_odd_i_not_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_re[n*DW +: DW] != MINV);
    end else begin : g_even
      p_even_q_not_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_im[n*DW +: DW] != MINV);
    end
  end
endmodule

bind chan_ifft32 chan_ifft32_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_chan_ifft32.sv
module tb_chan_ifft32;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] in_re = '0;
  logic [511:0] in_im = '0;
  logic         out_valid;
  logic [511:0] out_re;
  logic [511:0] out_im;

  chan_ifft32 dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re),
                   .in_im(in_im), .out_valid(out_valid), .out_re(out_re), .out_im(out_im));

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int xr[32];
  int xi[32];
  int q_er[$];
  int q_ei[$];
  int q_kind[$];
  int q_cyc[$];
  int unsigned seed = 32'h1234_5678;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rnd_int(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int clamp(int v, int lo);
    if (v > 32767) return 32767;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(int kind);
    real pi, sr, si, ang;
    pi = 3.14159265358979;
    for (int n = 0; n < 32; n++) begin
      sr = 0.0;
      si = 0.0;
      for (int k = 0; k < 32; k++) begin
        ang = 2.0 * pi * k * n / 32.0;
        sr += xr[k] * $cos(ang) - xi[k] * $sin(ang);
        si += xr[k] * $sin(ang) + xi[k] * $cos(ang);
      end
      sr /= 32.0;
      si /= 32.0;
      if (n % 2 == 1) begin
        q_er.push_back(clamp(-rnd_int(sr), -32767));
        q_ei.push_back(clamp(-rnd_int(si), -32768));
      end else begin
        q_er.push_back(clamp(rnd_int(sr), -32768));
        q_ei.push_back(clamp(rnd_int(si), -32767));
      end
    end
    @(negedge clk);
    for (int k = 0; k < 32; k++) begin
      in_re[k*16 +: 16] = 16'(xr[k]);
      in_im[k*16 +: 16] = 16'(xi[k]);
    end
    in_valid = 1'b1;
    q_kind.push_back(kind);
    q_cyc.push_back(cyc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_re = '0;
      in_im = '0;
    end
  endtask

  task automatic clear_bins();
    for (int k = 0; k < 32; k++) begin
      xr[k] = 0;
      xi[k] = 0;
    end
  endtask

  function automatic int next_rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % 32'd32001) - 16000;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_kind.size() == 0) begin
        check(1'b0, "R3", "output set without a pending input", 1, 0);
      end else begin
        int kind, c0, er, ei, ar, ai, bad_e, bad_o, be_a, be_x, bo_a, bo_x;
        bit nz, minodd;
        kind = q_kind.pop_front();
        c0 = q_cyc.pop_front();
        check(cyc - c0 == 5, "R3", "latency in cycles", cyc - c0, 5);
        bad_e = 0; bad_o = 0; nz = 1'b0; minodd = 1'b0;
        be_a = 0; be_x = 0; bo_a = 0; bo_x = 0;
        for (int n = 0; n < 32; n++) begin
          er = q_er.pop_front();
          ei = q_ei.pop_front();
          ar = int'($signed(out_re[n*16 +: 16]));
          ai = int'($signed(out_im[n*16 +: 16]));
          if (ar != 0 || ai != 0) nz = 1'b1;
          if (n % 2 == 1 && ar == -32768) minodd = 1'b1;
          if (n % 2 == 0 && ai == -32768) minodd = 1'b1;
          if (ar - er > 4 || er - ar > 4 || ai - ei > 4 || ei - ai > 4) begin
            if (n % 2 == 0) begin
              if (bad_e == 0) begin be_a = ar; be_x = er; end
              bad_e++;
            end else begin
              if (bad_o == 0) begin bo_a = ar; bo_x = er; end
              bad_o++;
            end
          end
        end
        check(bad_e == 0, "R1", "even channel value (first bad I)", be_a, be_x);
        check(bad_o == 0, "R2", "odd channel negated value (first bad I)", bo_a, bo_x);
        check(!minodd, "R6", "most negative value on a negated component", 1, 0);
        if (kind == 1) check(!nz, "R5", "zero input gives exact zero output", 1, 0);
        if (kind == 2) check(int'($signed(out_re[15:0])) == 23000, "R7", "full-scale channel 0",
                             int'($signed(out_re[15:0])), 23000);
        if (kind == 3) check(int'($signed(out_re[15:0])) == -32768, "R6", "even channel keeps -32768",
                             int'($signed(out_re[15:0])), -32768);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R4", "out_valid during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R4", "out_valid after reset, no input", int'(out_valid), 0);

    clear_bins();
    send(1);
    idle(2);

    clear_bins(); xr[0] = 16000; send(0);
    clear_bins(); xr[1] = 20000; send(0);
    clear_bins(); xr[7] = 12000; xi[7] = -9000; send(0);
    clear_bins(); xi[31] = 18000; send(0);
    idle(3);

    for (int k = 0; k < 32; k++) begin xr[k] = 23000; xi[k] = 0; end
    send(2);
    for (int k = 0; k < 32; k++) begin xr[k] = (k % 2 == 0) ? 20000 : -20000; xi[k] = 0; end
    send(0);
    for (int k = 0; k < 32; k++) begin xr[k] = -32768; xi[k] = 0; end
    send(3);
    idle(1);
    clear_bins();
    send(1);

    for (int v = 0; v < 30; v++) begin
      for (int k = 0; k < 32; k++) begin
        xr[k] = next_rnd();
        xi[k] = next_rnd();
      end
      send(0);
      if (v % 7 == 6) idle(2);
    end
    idle(10);

    check(q_kind.size() == 0, "R3", "pending sets after drain", q_kind.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule